// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and the next memory level. Every store the cache issues is placed in a small queue of block-sized slots, and the cache may treat the store as complete once the buffer accepts it. Each slot holds one block address, a set of data words and a bit per word marking which words hold data. If a new store falls in a block that already waits in the queue, it is folded into that slot instead of taking a new one. Fewer memory transactions result, and each one carries several words under a word mask.

Slots leave for memory strictly in the order they were opened. The oldest slot is shown on the memory port, and from that moment it is frozen: no further store merges into it, so the payload cannot change while memory holds off. A store to the block of the frozen slot opens a new slot behind it. When every slot is taken and the store matches none of the mergeable slots, the store is held off. A slot is freed in the same cycle the memory accepts it, and an incoming store may take that slot in that cycle.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the memory port shows no pending write (`mw_valid` low) and the store port is ready (`st_ready` high).
- R2: A store whose block matches no mergeable slot opens a new slot. The block address is `st_addr` bits [ADDR_W-1:4], the word index is bits [3:2], and bits [1:0] are ignored. When drained, the slot shows that block on `mw_addr`, a mask with only the bit of that word index set, and the store data in lane `i` (`mw_data` bits [32*i+31:32*i]).
- R3: A store whose block matches a queued slot that is not on the memory port merges into it. It sets the mask bit of its word and puts its data in that lane. The other lanes and mask bits are unchanged, and no new slot is used.
- R4: A later store to a word already present in a slot replaces the older data of that word.
- R5: The slot on the memory port takes no merges. A store to its block opens a new slot, and both slots drain separately, each with its own mask.
- R6: With all four slots occupied, `st_ready` is low for a store that matches no mergeable slot while no drain is accepted. It is high for a store that matches a mergeable slot.
- R7: With all slots occupied, a store that matches nothing is accepted in the cycle where memory accepts the oldest slot (`mw_valid` and `mw_ready` high), and it drains later as its own slot.
- R8: Slots drain in the order they were opened. After the last one is accepted, `mw_valid` is low.
- R9: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr`, `mw_data` and `mw_mask` hold their values, even while further stores are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W (32) | Byte address of the store |
| st_data | input | DATA_W (32) | Store data word |
| mw_valid | output | 1 | Oldest slot offered to memory |
| mw_ready | input | 1 | Memory takes the offered slot |
| mw_addr | output | ADDR_W-4 (28) | Block address of the offered slot |
| mw_data | output | WORDS*DATA_W (128) | Words of the offered slot, word i in lane i |
| mw_mask | output | WORDS (4) | Bit i set when word i carries data |

## Verification
The bench sweeps every non-empty word mask of a block, with a frozen slot at the head. A buffer that dropped a merge, wrote the wrong lane or opened extra slots would show a wrong mask, wrong data or a wrong drain count. It repeats a write to the same word to catch a merge that keeps stale data. It also stores to the block of the frozen head, which a buffer would wrongly fold into a payload memory is already looking at. A full buffer is driven three ways: a store that matches nothing and must stall, a store that merges and must pass, and a store that meets a drain in the same cycle. A buffer that got the last case wrong would either stall needlessly or overwrite the slot still being read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

   // write operation applied to one slot in a cycle
   typedef enum logic [1:0] {
      WR_IDLE  = 2'd0,
      WR_ALLOC = 2'd1,
      WR_MERGE = 2'd2
   } wr_op_e;

endpackage

// File: rtl/wbuf_entry.sv
module wbuf_entry
   import wbuf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int BLK_W  = 28,
   localparam int WIDX_W = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  wr_op_e                  op,
   input  logic                    clear,
   input  logic [WIDX_W-1:0]       wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [BLK_W-1:0]        wr_blk,
   output logic                    occ,
   output logic [BLK_W-1:0]        blk,
   output logic [WORDS*DATA_W-1:0] data,
   output logic [WORDS-1:0]        mask
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ  <= 1'b0;
         blk  <= '0;
         data <= '0;
         mask <= '0;
      end else if (op == WR_ALLOC) begin
         occ  <= 1'b1;
         blk  <= wr_blk;
         mask <= WORDS'(1) << wr_idx;
         for (int w = 0; w < WORDS; w++) begin
            data[w*DATA_W +: DATA_W] <= (WIDX_W'(w) == wr_idx) ? wr_data : '0;
         end
      end else if (op == WR_MERGE) begin
         mask[wr_idx]                   <= 1'b1;
         data[wr_idx*DATA_W +: DATA_W]  <= wr_data;
      end else if (clear) begin
         occ  <= 1'b0;
         mask <= '0;
      end
   end

   // R5
   merge_vs_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op == WR_MERGE && clear));

   // R3
   merge_needs_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == WR_MERGE) |-> occ);

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int DEPTH = 4,
   parameter int BLK_W = 28,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] occ,
   input  logic [BLK_W-1:0] blk [DEPTH],
   input  logic [PTR_W-1:0] head,
   input  logic [BLK_W-1:0] st_blk,
   output logic [DEPTH-1:0] hit
);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hit[i] = occ[i] && (blk[i] == st_blk) && (head != PTR_W'(i));
   end

   // R3
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
   import wbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int DEPTH  = 4,
   localparam int BYTE_OFF = $clog2(DATA_W / 8),
   localparam int WIDX_W   = $clog2(WORDS),
   localparam int BLK_LSB  = BYTE_OFF + WIDX_W,
   localparam int BLK_W    = ADDR_W - BLK_LSB,
   localparam int PTR_W    = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [DATA_W-1:0]       st_data,
   output logic                    mw_valid,
   input  logic                    mw_ready,
   output logic [BLK_W-1:0]        mw_addr,
   output logic [WORDS*DATA_W-1:0] mw_data,
   output logic [WORDS-1:0]        mw_mask
);

   // elaboration-time configuration checks
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("wbuf_merge: WORDS must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbuf_merge: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("wbuf_merge: DATA_W must be a power of two, at least 16");
   end
   if (BLK_W < 1) begin : g_bad_addr
      $error("wbuf_merge: ADDR_W too narrow for one block");
   end

   logic [PTR_W-1:0]        head, tail;
   logic [DEPTH-1:0]        occ, hit;
   logic [BLK_W-1:0]        blk_a  [DEPTH];
   logic [WORDS*DATA_W-1:0] data_a [DEPTH];
   logic [WORDS-1:0]        mask_a [DEPTH];

   logic [BLK_W-1:0]  st_blk;
   logic [WIDX_W-1:0] st_idx;
   logic              unused_byte_bits;
   logic              any_hit, drain_fire, alloc_fire, merge_fire;

   assign st_blk           = st_addr[ADDR_W-1:BLK_LSB];
   assign st_idx           = st_addr[BLK_LSB-1:BYTE_OFF];
   assign unused_byte_bits = ^st_addr[BYTE_OFF-1:0];

   wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .occ    (occ),
      .blk    (blk_a),
      .head   (head),
      .st_blk (st_blk),
      .hit    (hit)
   );

   assign any_hit    = |hit;
   assign mw_valid   = occ[head];
   assign drain_fire = mw_valid && mw_ready;
   // a full buffer has tail == head, so a drain frees exactly the tail slot
   assign st_ready   = any_hit || !occ[tail] || drain_fire;
   assign merge_fire = st_valid && any_hit;
   assign alloc_fire = st_valid && st_ready && !any_hit;

   assign mw_addr = blk_a[head];
   assign mw_data = data_a[head];
   assign mw_mask = mask_a[head];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      wr_op_e op_i;
      always_comb begin
         if (merge_fire && hit[i])                      op_i = WR_MERGE;
         else if (alloc_fire && tail == PTR_W'(i))      op_i = WR_ALLOC;
         else                                           op_i = WR_IDLE;
      end

      wbuf_entry #(.DATA_W(DATA_W), .WORDS(WORDS), .BLK_W(BLK_W)) u_entry (
         .clk     (clk),
         .rst_n   (rst_n),
         .op      (op_i),
         .clear   (drain_fire && head == PTR_W'(i)),
         .wr_idx  (st_idx),
         .wr_data (st_data),
         .wr_blk  (st_blk),
         .occ     (occ[i]),
         .blk     (blk_a[i]),
         .data    (data_a[i]),
         .mask    (mask_a[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else begin
         if (drain_fire) head <= head + 1'b1;
         if (alloc_fire) tail <= tail + 1'b1;
      end
   end

   // R9
   hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) &&
                                   $stable(mw_data) && $stable(mw_mask)));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_fire && occ[tail]) |-> drain_fire);

   // R2
   mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid |-> (mw_mask != '0));

   // R1
   reset_empty_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!mw_valid && st_ready));

endmodule

// File: tb/wbuf_merge_bench.sv
module wbuf_merge_bench;

   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0;
   logic         st_ready;
   logic [31:0]  st_addr = '0;
   logic [31:0]  st_data = '0;
   logic         mw_valid;
   logic         mw_ready = 1'b0;
   logic [27:0]  mw_addr;
   logic [127:0] mw_data;
   logic [3:0]   mw_mask;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wbuf_merge u_wbuf_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_valid (st_valid),
      .st_ready (st_ready),
      .st_addr  (st_addr),
      .st_data  (st_data),
      .mw_valid (mw_valid),
      .mw_ready (mw_ready),
      .mw_addr  (mw_addr),
      .mw_data  (mw_data),
      .mw_mask  (mw_mask)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] lanes(input logic [3:0] m);
      logic [127:0] r;
      for (int w = 0; w < 4; w++) r[w*32 +: 32] = m[w] ? 32'hFFFF_FFFF : 32'h0;
      return r;
   endfunction

   function automatic logic [31:0] adr(input logic [27:0] blk, input int w, input logic [1:0] lo);
      return {blk, w[1:0], lo};
   endfunction

   function automatic logic [31:0] dat(input int m, input int w);
      return 32'hA000_0000 | (m << 8) | w;
   endfunction

   task automatic push(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = a;
      st_data  = d;
      #1;
      while (!st_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   task automatic pop(input logic [27:0] ea, input logic [3:0] em,
                      input logic [127:0] ed, input string req);
      @(negedge clk);
      mw_ready = 1'b1;
      #1;
      check(req, mw_valid, 1);
      check(req, mw_addr, ea);
      check(req, mw_mask, em);
      check(req, mw_data & lanes(em), ed & lanes(em));
      @(posedge clk);
      #1 mw_ready = 1'b0;
   endtask

   task automatic expect_empty(input string req);
      @(negedge clk);
      #1;
      check(req, mw_valid, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [127:0] exp;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 state after reset
      @(negedge clk);
      #1;
      check("R1 ready", st_ready, 1);
      check("R1 idle", mw_valid, 0);

      // R2 single store, low byte bits ignored
      push(adr(28'h0010, 2, 2'b11), 32'hDEAD_BEEF);
      pop(28'h0010, 4'b0100, {32'h0, 32'hDEAD_BEEF, 64'h0}, "R2");
      expect_empty("R8 empty");

      // R3 sweep of every word mask behind a frozen head
      for (int m = 1; m < 16; m++) begin
         push(adr(28'h0100, 0, 2'b00), 32'h1);
         exp = '0;
         for (int w = 0; w < 4; w++) begin
            if (m[w]) begin
               push(adr(28'h0200 + 28'(m), w, 2'b00), dat(m, w));
               exp[w*32 +: 32] = dat(m, w);
            end
         end
         pop(28'h0100, 4'b0001, 128'h1, "R2 head");
         pop(28'h0200 + 28'(m), 4'(m), exp, "R3");
      end
      expect_empty("R8 empty");

      // R4 overwrite of one word
      push(adr(28'h0300, 0, 2'b00), 32'h3);
      push(adr(28'h0301, 1, 2'b00), 32'h0000_AAAA);
      push(adr(28'h0301, 1, 2'b00), 32'h0000_BBBB);
      push(adr(28'h0301, 3, 2'b00), 32'h0000_CCCC);
      pop(28'h0300, 4'b0001, 128'h3, "R4 head");
      pop(28'h0301, 4'b1010, {32'h0000_CCCC, 32'h0, 32'h0000_BBBB, 32'h0}, "R4");

      // R5 head is frozen
      push(adr(28'h0400, 0, 2'b00), 32'h11);
      push(adr(28'h0400, 1, 2'b00), 32'h22);
      pop(28'h0400, 4'b0001, 128'h11, "R5 first");
      pop(28'h0400, 4'b0010, {64'h0, 32'h22, 32'h0}, "R5 second");
      expect_empty("R5 empty");

      // R9 payload held while memory stalls
      push(adr(28'h0500, 2, 2'b00), 32'h55);
      push(adr(28'h0501, 0, 2'b00), 32'h5010);
      push(adr(28'h0501, 1, 2'b00), 32'h5011);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         #1;
         check("R9 valid", mw_valid, 1);
         check("R9 addr", mw_addr, 28'h0500);
         check("R9 mask", mw_mask, 4'b0100);
         check("R9 data", mw_data, {32'h0, 32'h55, 64'h0});
      end
      pop(28'h0500, 4'b0100, {32'h0, 32'h55, 64'h0}, "R9");
      pop(28'h0501, 4'b0011, {64'h0, 32'h5011, 32'h5010}, "R3 pair");

      // R6 / R7 / R8 full buffer
      for (int i = 0; i < 4; i++) push(adr(28'h0600 + 28'(i), i, 2'b00), 32'h600 + i);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = adr(28'h0610, 0, 2'b00);
      st_data  = 32'h6100;
      #1;
      check("R6 stall", st_ready, 0);
      st_addr = adr(28'h0601, 3, 2'b00);
      st_data = 32'h6013;
      #1;
      check("R6 merge while full", st_ready, 1);
      @(posedge clk);
      #1 st_valid = 1'b0;
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = adr(28'h0610, 0, 2'b00);
      st_data  = 32'h6100;
      #1;
      check("R6 stall again", st_ready, 0);
      mw_ready = 1'b1;
      #1;
      check("R7 ready on drain", st_ready, 1);
      check("R8 oldest", mw_addr, 28'h0600);
      check("R8 oldest mask", mw_mask, 4'b0001);
      @(posedge clk);
      #1;
      st_valid = 1'b0;
      mw_ready = 1'b0;
      pop(28'h0601, 4'b1010, {32'h6013, 32'h0, 32'h601, 32'h0}, "R8 second");
      pop(28'h0602, 4'b0100, {32'h0, 32'h602, 64'h0}, "R8 third");
      pop(28'h0603, 4'b1000, {32'h603, 96'h0}, "R8 fourth");
      pop(28'h0610, 4'b0001, 128'h6100, "R7 late slot");
      expect_empty("R8 drained");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule